// File: doc/BRIEF.md
# Software-Clocked Management Bus Bridge

This block lets software run a serial management bus one bit at a time through a 16-bit register port. Software writes a control/status word that holds a serial clock bit, an output data bit and an output-enable bit. The bridge compares each written word with the word written before it. When the clock bit goes from 0 to 1 between two writes, the bridge sends a single-cycle pulse to an external serial frame engine. The pulse carries a bit to shift in when output is enabled, and asks the engine for its next read-data bit when output is disabled.

Reading the control/status word returns the stored word with one field replaced by the engine's live input bit, so software samples the bus through that field. A second offset returns a chip identifier fixed by a parameter. Reads and writes at any other offset have no effect. A sticky flag records that such an access happened.

Top module: `mgmt_bitbang_bridge`

## Requirements
- R1: After reset the read data, both pulse outputs and the unmapped-access flag are 0, and the stored control/status word is 0.
- R2: A read at offset `ID_OFS` (default 0) returns the parameter `CHIP_ID` (default 16'h00C3) on `reg_rdata` in the cycle after `reg_rd`.
- R3: A read at offset `CSR_OFS` (default 1) returns the last word written there, with bit 3 replaced by the value of `eng_in_bit` in the `reg_rd` cycle.
- R4: A control/status write counts as a clock event only when bit 0 is 1 in the new word and 0 in the previously written word. No other write pulses either output.
- R5: On a clock event with bit 2 (output enable) set, `tx_pulse` is high for exactly the one cycle after the write, and `tx_bit` equals bit 1 of the written word.
- R6: On a clock event with bit 2 clear, `rx_pulse` is high for exactly the one cycle after the write, and `tx_pulse` stays low.
- R7: Every control/status write replaces the stored word, whether or not it is a clock event.
- R8: Reads at any other offset return 0. Writes at any other offset change neither the stored word nor the edge history. Either access sets `unmapped_seen`, which stays 1 until reset.
- R9: Because the stored word resets to 0, the first control/status write after reset with bit 0 set is a clock event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | ADDR_W | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after `reg_rd` and held until the next read |
| eng_in_bit | input | 1 | Live serial input bit from the frame engine |
| tx_pulse | output | 1 | One-cycle request to shift in `tx_bit` |
| tx_bit | output | 1 | Data bit that goes with `tx_pulse` |
| rx_pulse | output | 1 | One-cycle request to advance the engine's read-data bit |
| unmapped_seen | output | 1 | Sticky flag for an access at an unmapped offset |

## Verification
The assertions check on every cycle that the two pulses never appear together and that no pulse lasts two cycles. They also check that every pulse follows a write, that `tx_bit` matches the data bit just written, that the identifier and live input bit show up in read data, and that the unmapped flag never clears. Only the bench scenarios can show that edges are judged against the previous written word. That covers a held-high clock giving no pulse, the first write after reset counting as an edge, unmapped writes leaving the history alone, and readback keeping every stored bit apart from bit 3.

// File: rtl/mbb_pkg.sv
package mbb_pkg;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned CLK_BIT  = 0;
  localparam int unsigned DOUT_BIT = 1;
  localparam int unsigned OE_BIT   = 2;
  localparam int unsigned DIN_BIT  = 3;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/mbb_rst_sync.sv
module mbb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mbb_regfile.sv
module mbb_regfile
  import mbb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned ID_OFS  = 0,
  parameter int unsigned CSR_OFS = 1,
  parameter word_t       CHIP_ID = 16'h00C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  word_t             reg_wdata,
  input  logic              eng_in_bit,
  output word_t             reg_rdata,
  output word_t             csr_q,
  output logic              csr_wr,
  output logic              unmapped_seen
);
  localparam logic [ADDR_W-1:0] ID_A  = ADDR_W'(ID_OFS);
  localparam logic [ADDR_W-1:0] CSR_A = ADDR_W'(CSR_OFS);

  logic  hit_id, hit_csr, miss;
  logic  csr_en, rd_en, flag_d;
  word_t csr_d, rdata_d, csr_view;

  always_comb begin
    hit_id   = (reg_addr == ID_A);
    hit_csr  = (reg_addr == CSR_A);
    miss     = !hit_id && !hit_csr;
    csr_wr   = reg_wr && hit_csr;
    csr_en   = csr_wr;
    csr_d    = reg_wdata;
    csr_view = csr_q;
    csr_view[DIN_BIT] = eng_in_bit;
    rd_en    = reg_rd;
    if (hit_id)       rdata_d = CHIP_ID;
    else if (hit_csr) rdata_d = csr_view;
    else              rdata_d = '0;
    flag_d   = unmapped_seen || ((reg_wr || reg_rd) && miss);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q         <= '0;
      reg_rdata     <= '0;
      unmapped_seen <= 1'b0;
    end else begin
      if (csr_en) csr_q <= csr_d;
      if (rd_en)  reg_rdata <= rdata_d;
      unmapped_seen <= flag_d;
    end
  end

  AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ID_A) |=> (reg_rdata == CHIP_ID)); // R2
  AST_DIN_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == CSR_A) |=> (reg_rdata[DIN_BIT] == $past(eng_in_bit))); // R3
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr != ID_A && reg_addr != CSR_A) |=> (reg_rdata == '0)); // R8
  AST_STICKY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_seen |=> unmapped_seen); // R8
endmodule

// File: rtl/mbb_edge_det.sv
module mbb_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic csr_wr,
  input  logic wr_clk,
  input  logic wr_dout,
  input  logic wr_oe,
  input  logic prev_clk,
  output logic tx_pulse,
  output logic tx_bit,
  output logic rx_pulse
);
  logic rise, tx_d, rx_d, bit_d, bit_en;

  always_comb begin
    rise   = csr_wr && wr_clk && !prev_clk;
    tx_d   = rise && wr_oe;
    rx_d   = rise && !wr_oe;
    bit_en = tx_d;
    bit_d  = wr_dout;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_pulse <= 1'b0;
      rx_pulse <= 1'b0;
      tx_bit   <= 1'b0;
    end else begin
      tx_pulse <= tx_d;
      rx_pulse <= rx_d;
      if (bit_en) tx_bit <= bit_d;
    end
  end

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_pulse && rx_pulse)); // R6
  AST_TX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pulse |=> !tx_pulse); // R4
  AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pulse |=> !rx_pulse); // R4
  AST_PULSE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_pulse || rx_pulse) |-> $past(csr_wr)); // R4
  AST_TX_BIT_VAL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pulse |-> (tx_bit == $past(wr_dout))); // R5
endmodule

// File: rtl/mgmt_bitbang_bridge.sv
module mgmt_bitbang_bridge
  import mbb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned ID_OFS  = 0,
  parameter int unsigned CSR_OFS = 1,
  parameter logic [15:0] CHIP_ID = 16'h00C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              eng_in_bit,
  output logic              tx_pulse,
  output logic              tx_bit,
  output logic              rx_pulse,
  output logic              unmapped_seen
);
  logic  rst_sync_n;
  logic  csr_wr;
  word_t csr_q;

  mbb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mbb_regfile #(
    .ADDR_W  (ADDR_W),
    .ID_OFS  (ID_OFS),
    .CSR_OFS (CSR_OFS),
    .CHIP_ID (CHIP_ID)
  ) u_regs (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .reg_addr      (reg_addr),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .reg_wdata     (reg_wdata),
    .eng_in_bit    (eng_in_bit),
    .reg_rdata     (reg_rdata),
    .csr_q         (csr_q),
    .csr_wr        (csr_wr),
    .unmapped_seen (unmapped_seen)
  );

  mbb_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .csr_wr   (csr_wr),
    .wr_clk   (reg_wdata[CLK_BIT]),
    .wr_dout  (reg_wdata[DOUT_BIT]),
    .wr_oe    (reg_wdata[OE_BIT]),
    .prev_clk (csr_q[CLK_BIT]),
    .tx_pulse (tx_pulse),
    .tx_bit   (tx_bit),
    .rx_pulse (rx_pulse)
  );
endmodule

// File: tb/mgmt_bitbang_bridge_tb.sv
module mgmt_bitbang_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        eng_in_bit = 1'b0;
  logic        tx_pulse, tx_bit, rx_pulse, unmapped_seen;
  int          n_chk = 0;
  int          n_err = 0;
  logic        done = 1'b0;

  localparam logic [3:0] A_ID = 4'd0, A_CSR = 4'd1, A_BAD = 4'd5;

  always #2 clk = ~clk;

  mgmt_bitbang_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_in_bit(eng_in_bit), .tx_pulse(tx_pulse), .tx_bit(tx_bit),
    .rx_pulse(rx_pulse), .unmapped_seen(unmapped_seen)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic pulses(input string req, input logic t, input logic r);
    check({req, " tx_pulse"}, {15'd0, tx_pulse}, {15'd0, t});
    check({req, " rx_pulse"}, {15'd0, rx_pulse}, {15'd0, r});
  endtask

  task automatic t_reset;
    check("R1 rdata", reg_rdata, 16'h0);
    pulses("R1", 1'b0, 1'b0);
    check("R1 flag", {15'd0, unmapped_seen}, 16'h0);
  endtask

  task automatic t_id;
    logic [15:0] d;
    rd(A_ID, d); check("R2 id", d, 16'h00C3);
  endtask

  task automatic t_first_edge;
    logic [15:0] d;
    wr(A_CSR, 16'h0005);                 // clk=1 oe=1 dout=0 first write: R9
    pulses("R9", 1'b1, 1'b0);
    check("R5 tx_bit", {15'd0, tx_bit}, 16'h0);
    @(negedge clk); pulses("R5 one cycle", 1'b0, 1'b0);
    rd(A_CSR, d); check("R1/R7 stored", d, 16'h0005);
  endtask

  task automatic t_hold_and_rise;
    wr(A_CSR, 16'h0007);                 // clock still 1: no event, R4
    pulses("R4 held", 1'b0, 1'b0);
    wr(A_CSR, 16'h0006);                 // clock falls
    pulses("R4 fall", 1'b0, 1'b0);
    wr(A_CSR, 16'h0007);                 // rises, dout=1
    pulses("R5 rise", 1'b1, 1'b0);
    check("R5 tx_bit", {15'd0, tx_bit}, 16'h0001);
  endtask

  task automatic t_rx;
    wr(A_CSR, 16'h0000);
    pulses("R6 low", 1'b0, 1'b0);
    wr(A_CSR, 16'h0003);                 // oe=0, dout ignored
    pulses("R6 rx", 1'b0, 1'b1);
    @(negedge clk); pulses("R6 one cycle", 1'b0, 1'b0);
  endtask

  task automatic t_readback;
    logic [15:0] d;
    eng_in_bit = 1'b1;
    wr(A_CSR, 16'h00F0);
    rd(A_CSR, d); check("R3 din=1", d, 16'h00F8);
    eng_in_bit = 1'b0;
    wr(A_CSR, 16'hABCF);
    rd(A_CSR, d); check("R3 din=0", d, 16'hABC7);
  endtask

  task automatic t_store_always;
    logic [15:0] d;
    wr(A_CSR, 16'h1235);                 // previous clk=1: no event but stored
    pulses("R7 no edge", 1'b0, 1'b0);
    rd(A_CSR, d); check("R7 stored", d, 16'h1235);
    wr(A_CSR, 16'h0000);
  endtask

  task automatic t_unmapped;
    logic [15:0] d;
    check("R8 flag before", {15'd0, unmapped_seen}, 16'h0);
    wr(A_BAD, 16'hFFFF);
    pulses("R8 bad write", 1'b0, 1'b0);
    check("R8 flag set", {15'd0, unmapped_seen}, 16'h0001);
    rd(A_CSR, d); check("R8 csr kept", d, 16'h0000);
    rd(A_BAD, d); check("R8 read zero", d, 16'h0000);
    wr(A_CSR, 16'h0001);                 // history still clk=0 -> edge
    pulses("R8 history kept", 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    check("R8 flag sticky", {15'd0, unmapped_seen}, 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_id();
    t_first_edge();
    t_hold_and_rise();
    t_rx();
    t_readback();
    t_store_always();
    t_unmapped();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=running expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule